// File: doc/BRIEF.md
# Auxiliary Channel Transaction Sequencer

This block carries out one request/reply exchange on the auxiliary side channel of a display link. A client presents a 4-bit command, a 20-bit target address, a byte count from 1 to 16 and up to 16 bytes of write payload, then pulses `start_i`. The sequencer runs the exchange to completion and returns a one-cycle `done_o`, a 3-bit result code and, for reads, the received bytes.

The exchange has a fixed order. First the sequencer waits for the channel engine to report that no earlier exchange is still active. It then raises an ownership request and waits for the grant. Next it checks that a sink is attached. It loads the staging registers and runs up to `MAX_TRIES` attempts. Each attempt begins with a one-cycle reset pulse to the engine. Every attempt after the first waits a back-off interval before the go request is raised. The go request is held until the engine reports completion, together with an error vector that is all zero on success. Every waiting phase has a limit counted in microseconds. A microsecond is `CYC_PER_US` clock cycles, so the same RTL runs with real delays on silicon and with short delays in simulation. The ownership request is dropped when the exchange ends, whatever the outcome.

Result codes: 0 success, 1 channel busy, 2 no sink, 3 completion timeout, 4 remote error after all attempts.

Top module: `aux_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `ch_req_o`, `ch_rst_o` and `ch_go_o` are low, and `status_o` and `rdata_o` are zero.
- R2: While `ch_busy_i` is high the ownership request stays low. If `ch_busy_i` stays high for longer than `TIMEOUT_US` microseconds, the exchange ends with code 1 and no request is ever raised.
- R3: Once the channel is free, `ch_req_o` rises. If `ch_gnt_i` does not arrive within `TIMEOUT_US` microseconds, the exchange ends with code 1.
- R4: If `sink_present_i` is low after the grant, the exchange ends with code 2 and no reset pulse or go request is issued.
- R5: While `ch_go_o` is high, `ch_addr_o` and `ch_cmd_o` hold the start values and `ch_size_o` holds the byte count minus one. For writes (command bit 0 = 0), `ch_wdata_o` holds the start payload.
- R6: On a successful read (command bit 0 = 1), `rdata_o` byte i equals `ch_rx_i` byte i for i below the byte count, and zero above it. `rdata_o` is cleared at every start, so writes and failed exchanges return zero.
- R7: Each attempt begins with exactly one cycle of `ch_rst_o`, never in the same cycle as `ch_go_o`. On the first attempt, `ch_go_o` rises in the cycle right after the reset pulse.
- R8: On every attempt after the first, at least `BACKOFF_US` microseconds pass between the reset pulse and the rise of `ch_go_o`.
- R9: `ch_go_o` stays high until `ch_done_i`. If no completion arrives within `TIMEOUT_US` microseconds, the exchange ends with code 3 and no further attempt is made. A completion in the same cycle that the limit expires counts as a completion.
- R10: An attempt succeeds when `ch_err_i` is zero at completion, and the exchange ends with code 0. Otherwise a new attempt starts. After `MAX_TRIES` failed attempts, the exchange ends with code 4.
- R11: `done_o` lasts exactly one cycle. `ch_req_o` is low in that cycle, and `busy_o` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an exchange (ignored while busy) |
| cmd_i | input | 4 | Command type; bit 0 set means read |
| addr_i | input | 20 | Target address |
| len_i | input | 5 | Byte count, 1 to 16 |
| wdata_i | input | 128 | Write payload, byte 0 in bits 7:0 |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle end-of-exchange strobe |
| status_o | output | 3 | Result code of the last exchange |
| rdata_o | output | 128 | Read bytes, unused bytes zero |
| ch_busy_i | input | 1 | Engine still busy with an earlier exchange |
| ch_req_o | output | 1 | Channel ownership request |
| ch_gnt_i | input | 1 | Ownership grant |
| sink_present_i | input | 1 | A sink is attached |
| ch_rst_o | output | 1 | Per-attempt reset pulse |
| ch_go_o | output | 1 | Attempt request, held until completion |
| ch_done_i | input | 1 | Attempt completion strobe |
| ch_err_i | input | 8 | Reply error flags, valid with ch_done_i |
| ch_rx_i | input | 128 | Engine receive buffer |
| ch_addr_o | output | 20 | Staged address |
| ch_cmd_o | output | 4 | Staged command |
| ch_size_o | output | 4 | Staged byte count minus one |
| ch_wdata_o | output | 128 | Staged write payload |

## Verification
The completion strobe and the expiry of the completion limit can fall in the same cycle. This is the case where the outcome depends on a priority, because both move the sequencer out of its wait state. The bench model sets the completion latency to exactly the limit in one vector and to one cycle more in the next. The first vector must end in success and the second in a timeout, with one reset pulse each. A related boundary is an error completion on the last allowed attempt. That attempt must end with the remote-error code and no further reset pulse, whereas a clean completion on the attempt just before it must still succeed.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_BUSY    = 3'd1,
    RES_NODEV   = 3'd2,
    RES_TIMEOUT = 3'd3,
    RES_REMOTE  = 3'd4
  } aux_res_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WAIT_FREE,
    S_ACQ,
    S_SINK,
    S_RST,
    S_BACKOFF,
    S_XFER,
    S_FIN
  } aux_state_e;

endpackage

// File: rtl/aux_seq_timer.sv
module aux_seq_timer #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);

  logic [W-1:0] cnt_q;

  assign hit_o = (cnt_q >= limit_i);

  // saturates at the limit so a long wait never wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (!hit_o)   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/aux_seq_stage.sv
module aux_seq_stage #(
  parameter int NBYTES = 16,
  parameter int AW     = 20,
  parameter int CW     = 4,
  localparam int LW    = $clog2(NBYTES + 1),
  localparam int SW    = $clog2(NBYTES),
  localparam int DW    = 8 * NBYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          cap_i,
  input  logic [CW-1:0] cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rx_i,
  output logic          is_read_o,
  output logic [AW-1:0] ch_addr_o,
  output logic [CW-1:0] ch_cmd_o,
  output logic [SW-1:0] ch_size_o,
  output logic [DW-1:0] ch_wdata_o,
  output logic [DW-1:0] rdata_o
);

  logic [LW-1:0] len_q;
  logic [LW-1:0] len_m1;

  assign len_m1    = len_i - LW'(1);
  assign is_read_o = ch_cmd_o[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_addr_o  <= '0;
      ch_cmd_o   <= '0;
      ch_size_o  <= '0;
      ch_wdata_o <= '0;
      len_q      <= '0;
    end else if (load_i) begin
      ch_addr_o <= addr_i;
      ch_cmd_o  <= cmd_i;
      ch_size_o <= len_m1[SW-1:0];
      len_q     <= len_i;
      if (!cmd_i[0]) ch_wdata_o <= wdata_i;
    end
  end

  // per-byte capture with masking beyond the requested count
  for (genvar b = 0; b < NBYTES; b++) begin : g_rx
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     byte_q <= '0;
      else if (load_i) byte_q <= '0;
      else if (cap_i)  byte_q <= (LW'(b) < len_q) ? rx_i[8*b +: 8] : 8'h00;
    end
    assign rdata_o[8*b +: 8] = byte_q;
  end

endmodule

// File: rtl/aux_seq_ctrl.sv
module aux_seq_ctrl
  import aux_seq_pkg::*;
#(
  parameter int TO_CYC    = 4000,
  parameter int BO_CYC    = 1600,
  parameter int MAX_TRIES = 32,
  parameter int TW        = 12,
  localparam int NW       = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          is_read_i,
  input  logic          ch_busy_i,
  input  logic          ch_gnt_i,
  input  logic          sink_i,
  input  logic          xfer_done_i,
  input  logic          err_any_i,
  input  logic          tmr_hit_i,
  output logic          tmr_clr_o,
  output logic [TW-1:0] tmr_limit_o,
  output logic          load_o,
  output logic          cap_o,
  output logic          ch_req_o,
  output logic          ch_rst_o,
  output logic          ch_go_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    status_o
);

  aux_state_e    state_q, state_d;
  aux_res_e      res_q, res_d;
  logic [NW-1:0] tries_q, tries_d;

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    tries_d = tries_q;
    load_o  = 1'b0;
    cap_o   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          tries_d = '0;
          state_d = S_WAIT_FREE;
        end
      end
      S_WAIT_FREE: begin
        if (!ch_busy_i) begin
          state_d = S_ACQ;
        end else if (tmr_hit_i) begin
          res_d   = RES_BUSY;
          state_d = S_FIN;
        end
      end
      S_ACQ: begin
        if (ch_gnt_i) begin
          state_d = S_SINK;
        end else if (tmr_hit_i) begin
          res_d   = RES_BUSY;
          state_d = S_FIN;
        end
      end
      S_SINK: begin
        if (!sink_i) begin
          res_d   = RES_NODEV;
          state_d = S_FIN;
        end else begin
          state_d = S_RST;
        end
      end
      S_RST: begin
        state_d = (tries_q != '0) ? S_BACKOFF : S_XFER;
      end
      S_BACKOFF: begin
        if (tmr_hit_i) state_d = S_XFER;
      end
      S_XFER: begin
        // completion wins over an expiry in the same cycle
        if (xfer_done_i) begin
          if (!err_any_i) begin
            cap_o   = is_read_i;
            res_d   = RES_OK;
            state_d = S_FIN;
          end else if (tries_q == NW'(MAX_TRIES - 1)) begin
            res_d   = RES_REMOTE;
            state_d = S_FIN;
          end else begin
            tries_d = tries_q + 1'b1;
            state_d = S_RST;
          end
        end else if (tmr_hit_i) begin
          res_d   = RES_TIMEOUT;
          state_d = S_FIN;
        end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      res_q   <= RES_OK;
      tries_q <= '0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      tries_q <= tries_d;
    end
  end

  assign tmr_clr_o   = (state_d != state_q);
  assign tmr_limit_o = (state_q == S_BACKOFF) ? TW'(BO_CYC) : TW'(TO_CYC);

  assign ch_req_o = (state_q == S_ACQ) || (state_q == S_SINK) || (state_q == S_RST) ||
                    (state_q == S_BACKOFF) || (state_q == S_XFER);
  assign ch_rst_o = (state_q == S_RST);
  assign ch_go_o  = (state_q == S_XFER);
  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_FIN);
  assign status_o = res_q;

endmodule

// File: rtl/aux_seq.sv
module aux_seq #(
  parameter int CYC_PER_US = 4,
  parameter int TIMEOUT_US = 1000,
  parameter int BACKOFF_US = 400,
  parameter int MAX_TRIES  = 32,
  parameter int NBYTES     = 16,
  parameter int AW         = 20,
  parameter int CW         = 4,
  parameter int EW         = 8,
  localparam int LW        = $clog2(NBYTES + 1),
  localparam int SW        = $clog2(NBYTES),
  localparam int DW        = 8 * NBYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    status_o,
  output logic [DW-1:0] rdata_o,
  input  logic          ch_busy_i,
  output logic          ch_req_o,
  input  logic          ch_gnt_i,
  input  logic          sink_present_i,
  output logic          ch_rst_o,
  output logic          ch_go_o,
  input  logic          ch_done_i,
  input  logic [EW-1:0] ch_err_i,
  input  logic [DW-1:0] ch_rx_i,
  output logic [AW-1:0] ch_addr_o,
  output logic [CW-1:0] ch_cmd_o,
  output logic [SW-1:0] ch_size_o,
  output logic [DW-1:0] ch_wdata_o
);

  localparam int TO_CYC = TIMEOUT_US * CYC_PER_US;
  localparam int BO_CYC = BACKOFF_US * CYC_PER_US;
  localparam int TW     = $clog2(((TO_CYC > BO_CYC) ? TO_CYC : BO_CYC) + 1);

  logic          load, cap, is_read;
  logic          tmr_clr, tmr_hit;
  logic [TW-1:0] tmr_limit;

  aux_seq_timer #(.W(TW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .limit_i (tmr_limit),
    .hit_o   (tmr_hit)
  );

  aux_seq_stage #(.NBYTES(NBYTES), .AW(AW), .CW(CW)) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .cap_i      (cap),
    .cmd_i      (cmd_i),
    .addr_i     (addr_i),
    .len_i      (len_i),
    .wdata_i    (wdata_i),
    .rx_i       (ch_rx_i),
    .is_read_o  (is_read),
    .ch_addr_o  (ch_addr_o),
    .ch_cmd_o   (ch_cmd_o),
    .ch_size_o  (ch_size_o),
    .ch_wdata_o (ch_wdata_o),
    .rdata_o    (rdata_o)
  );

  aux_seq_ctrl #(
    .TO_CYC    (TO_CYC),
    .BO_CYC    (BO_CYC),
    .MAX_TRIES (MAX_TRIES),
    .TW        (TW)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .is_read_i   (is_read),
    .ch_busy_i   (ch_busy_i),
    .ch_gnt_i    (ch_gnt_i),
    .sink_i      (sink_present_i),
    .xfer_done_i (ch_done_i),
    .err_any_i   (|ch_err_i),
    .tmr_hit_i   (tmr_hit),
    .tmr_clr_o   (tmr_clr),
    .tmr_limit_o (tmr_limit),
    .load_o      (load),
    .cap_o       (cap),
    .ch_req_o    (ch_req_o),
    .ch_rst_o    (ch_rst_o),
    .ch_go_o     (ch_go_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .status_o    (status_o)
  );

endmodule

// File: rtl/aux_seq_chk.sv
module aux_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic done_o,
  input logic ch_req_o,
  input logic ch_rst_o,
  input logic ch_go_o,
  input logic ch_busy_i,
  input logic ch_done_i
);

  assert_free_before_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ch_req_o) |-> !$past(ch_busy_i));

  assert_rst_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_rst_o |=> !ch_rst_o);

  assert_rst_not_go_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_rst_o |-> !ch_go_o);

  assert_go_owned_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_go_o |-> ch_req_o);

  assert_go_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_go_o && !ch_done_i) |=> (ch_go_o || done_o));

  assert_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ch_req_o);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

bind aux_seq aux_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .done_o    (done_o),
  .ch_req_o  (ch_req_o),
  .ch_rst_o  (ch_rst_o),
  .ch_go_o   (ch_go_o),
  .ch_busy_i (ch_busy_i),
  .ch_done_i (ch_done_i)
);

// File: tb/aux_seq_tb.sv
module aux_seq_tb;

  localparam int CPU = 2;
  localparam int TOU = 10;
  localparam int BOU = 4;
  localparam int MT  = 4;
  localparam int TO_CYC = TOU * CPU;
  localparam int BO_CYC = BOU * CPU;

  typedef struct packed {
    logic [3:0] cmd;
    logic [4:0] len;
    logic [7:0] busy;   // cycles ch_busy_i stays high
    logic       gnt;
    logic       sink;
    logic [3:0] fails;  // attempts answered with an error
    logic [7:0] dl;     // completion latency after go rises
    logic [2:0] res;
    logic [2:0] nrst;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'h8, 5'd2,  8'd0,  1'b1, 1'b1, 4'd0, 8'd3,  3'd0, 3'd1},
    '{4'h9, 5'd16, 8'd0,  1'b1, 1'b1, 4'd0, 8'd3,  3'd0, 3'd1},
    '{4'h9, 5'd5,  8'd0,  1'b1, 1'b1, 4'd2, 8'd4,  3'd0, 3'd3},
    '{4'h8, 5'd1,  8'd0,  1'b1, 1'b1, 4'd4, 8'd2,  3'd4, 3'd4},
    '{4'h9, 5'd3,  8'd0,  1'b1, 1'b1, 4'd9, 8'd2,  3'd4, 3'd4},
    '{4'h9, 5'd4,  8'd40, 1'b1, 1'b1, 4'd0, 8'd3,  3'd1, 3'd0},
    '{4'h9, 5'd7,  8'd5,  1'b1, 1'b1, 4'd0, 8'd3,  3'd0, 3'd1},
    '{4'h8, 5'd4,  8'd0,  1'b0, 1'b1, 4'd0, 8'd3,  3'd1, 3'd0},
    '{4'h9, 5'd4,  8'd0,  1'b1, 1'b0, 4'd0, 8'd3,  3'd2, 3'd0},
    '{4'h9, 5'd8,  8'd0,  1'b1, 1'b1, 4'd0, 8'd20, 3'd0, 3'd1},
    '{4'h9, 5'd8,  8'd0,  1'b1, 1'b1, 4'd0, 8'd21, 3'd3, 3'd1},
    '{4'h9, 5'd1,  8'd0,  1'b1, 1'b1, 4'd3, 8'd20, 3'd0, 3'd4}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   cmd = '0;
  logic [19:0]  addr = '0;
  logic [4:0]   len = 5'd1;
  logic [127:0] wdata = '0;
  logic         busy, done;
  logic [2:0]   status;
  logic [127:0] rdata;
  logic         ch_busy = 1'b0;
  logic         ch_req, ch_rst, ch_go;
  logic         ch_gnt;
  logic         sink = 1'b1;
  logic         ch_done;
  logic [7:0]   ch_err;
  logic [127:0] ch_rx = '0;
  logic [19:0]  ch_addr;
  logic [3:0]   ch_cmd;
  logic [3:0]   ch_size;
  logic [127:0] ch_wdata;

  int   n_tests = 0;
  int   n_fail  = 0;
  logic gnt_en  = 1'b1;
  int   fails_cur = 0;
  int   dl_cur  = 3;
  int   att     = 0;
  logic [7:0] go_cnt;

  always #4 clk = ~clk;

  aux_seq #(
    .CYC_PER_US (CPU),
    .TIMEOUT_US (TOU),
    .BACKOFF_US (BOU),
    .MAX_TRIES  (MT)
  ) u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .start_i        (start),
    .cmd_i          (cmd),
    .addr_i         (addr),
    .len_i          (len),
    .wdata_i        (wdata),
    .busy_o         (busy),
    .done_o         (done),
    .status_o       (status),
    .rdata_o        (rdata),
    .ch_busy_i      (ch_busy),
    .ch_req_o       (ch_req),
    .ch_gnt_i       (ch_gnt),
    .sink_present_i (sink),
    .ch_rst_o       (ch_rst),
    .ch_go_o        (ch_go),
    .ch_done_i      (ch_done),
    .ch_err_i       (ch_err),
    .ch_rx_i        (ch_rx),
    .ch_addr_o      (ch_addr),
    .ch_cmd_o       (ch_cmd),
    .ch_size_o      (ch_size),
    .ch_wdata_o     (ch_wdata)
  );

  // channel engine model
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_gnt  <= 1'b0;
      ch_done <= 1'b0;
      go_cnt  <= '0;
    end else begin
      ch_gnt  <= ch_req && gnt_en;
      go_cnt  <= ch_go ? go_cnt + 8'd1 : 8'd0;
      ch_done <= ch_go && (int'(go_cnt) == dl_cur - 1);
    end
  end
  assign ch_err = (att <= fails_cur) ? 8'h10 : 8'h00;

  task automatic check(input logic ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string res_tag(input logic [2:0] r);
    case (r)
      3'd1:    return "R2/R3 busy";
      3'd2:    return "R4 nodev";
      3'd3:    return "R9 timeout";
      3'd4:    return "R10 remote";
      default: return "R10 ok";
    endcase
  endfunction

  task automatic run_vec(input int vi);
    vec_t v;
    logic [127:0] wd, rx, exp_rd;
    logic [19:0]  ad;
    logic [19:0]  s_addr;
    logic [3:0]   s_cmd, s_size;
    logic [127:0] s_wd;
    int cyc, last_rst, first_gap, min_gap;
    logic req_seen, go_prev, got;
    v = VECS[vi];
    ad = 20'h00100 + 20'(vi * 'h111);
    for (int b = 0; b < 16; b++) begin
      wd[8*b +: 8] = 8'hC0 ^ 8'(vi * 7 + b);
      rx[8*b +: 8] = 8'h40 + 8'(vi * 16 + b);
    end
    exp_rd = '0;
    if (v.cmd[0] && v.res == 3'd0)
      for (int b = 0; b < 16; b++) if (b < int'(v.len)) exp_rd[8*b +: 8] = rx[8*b +: 8];
    @(negedge clk);
    gnt_en = v.gnt; sink = v.sink; fails_cur = int'(v.fails); dl_cur = int'(v.dl);
    att = 0; ch_rx = rx; ch_busy = (v.busy != 0);
    cmd = v.cmd; addr = ad; len = v.len; wdata = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; last_rst = 0; first_gap = -1; min_gap = 9999;
    req_seen = 1'b0; go_prev = 1'b0; got = 1'b0;
    s_addr = '0; s_cmd = '0; s_size = '0; s_wd = '0;
    while (!got && cyc < 3000) begin
      if (cyc == int'(v.busy)) ch_busy = 1'b0;
      if (ch_req) req_seen = 1'b1;
      if (ch_rst) begin att++; last_rst = cyc; end
      if (ch_go && !go_prev) begin
        if (att == 1) first_gap = cyc - last_rst;
        else if (cyc - last_rst < min_gap) min_gap = cyc - last_rst;
        s_addr = ch_addr; s_cmd = ch_cmd; s_size = ch_size; s_wd = ch_wdata;
      end
      go_prev = ch_go;
      if (done) begin
        got = 1'b1;
        check(!ch_req, "R11 release at done", 128'(ch_req), 128'd0);
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    check(got, "watchdog per vector", 128'(got), 128'd1);
    check(status == v.res, res_tag(v.res), 128'(status), 128'(v.res));
    check(att == int'(v.nrst), "R10/R7 attempt count", 128'(att), 128'(v.nrst));
    check(rdata == exp_rd, "R6 read data", rdata, exp_rd);
    if (v.busy > 8'd20) check(!req_seen, "R2 no request while busy", 128'(req_seen), 128'd0);
    if (!v.gnt) check(req_seen, "R3 request raised", 128'(req_seen), 128'd1);
    if (v.nrst != 0) begin
      check(s_addr == ad, "R5 staged address", 128'(s_addr), 128'(ad));
      check(s_cmd == v.cmd, "R5 staged command", 128'(s_cmd), 128'(v.cmd));
      check(s_size == 4'(v.len - 5'd1), "R5 staged size", 128'(s_size), 128'(v.len - 5'd1));
      if (!v.cmd[0]) check(s_wd == wd, "R5 staged payload", s_wd, wd);
      check(first_gap == 1, "R7 first go after reset", 128'(first_gap), 128'd1);
    end
    if (v.nrst > 1)
      check(min_gap >= BO_CYC, "R8 back-off", 128'(min_gap), 128'(BO_CYC));
    @(negedge clk);
    check(!done, "R11 done one cycle", 128'(done), 128'd0);
    check(!busy, "R11 idle after done", 128'(busy), 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R1
    check(!busy && !done && !ch_req && !ch_rst && !ch_go, "R1 reset controls",
          {123'd0, busy, done, ch_req, ch_rst, ch_go}, 128'd0);
    check(status == 3'd0, "R1 reset status", 128'(status), 128'd0);
    check(rdata == '0, "R1 reset rdata", rdata, 128'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !ch_req, "R1 idle after reset", {126'd0, busy, ch_req}, 128'd0);
    for (int vi = 0; vi < NV; vi++) run_vec(vi);
    // R4: no sink means no attempt at all (vector 8 above); also no go seen at idle
    check(!ch_go && !ch_rst, "R4 idle channel quiet", {126'd0, ch_go, ch_rst}, 128'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule